// File: doc/BRIEF.md
# Page-Granular Execute Protection Unit

This unit sits next to a CPU bus and checks instruction fetches only. Every bus cycle that carries the fetch qualifier is classified by address into one of four windows. The windows are the low RAM range, a mirror of that RAM one RAM-size above it, an archive (flash) range, and everything else. A fetch that the active rule forbids produces a registered one-cycle fault pulse, which the surrounding system uses to force a reset. Data reads and writes pass without any check.

Low RAM is cut into 4 KB pages, and each page has its own execute-forbidden bit. The mirror window does not look at per-page bits. It follows only the bit of the highest RAM page. The archive range is guarded by a movable page boundary: fetches at or above the boundary are refused, and fetches below it are allowed. A small register port lets software rewrite the page mask and the boundary. The same port reads back the address of the first fault taken since reset.

Top module: `xprot_guard`

## Requirements
- R1: After reset, config words 0..3 read 0xFFDF, 0xFFFF, 0xFFFF, 0xFFFF. Only page 5 (0x005000–0x005FFF) is executable. Word 4 reads 0x0200 and words 5 and 6 read 0x0000.
- R2: A fetch to 0x000000–0x03FFFF uses page index addr[17:12]. It faults when that page's bit is 1 and does not fault when the bit is 0.
- R3: With reset settings, a fetch inside page 5 does not fault, and a fetch in the neighbouring page 4 does fault.
- R4: Config word k (k = 0..3) holds the bits of pages 16k..16k+15, with bit j belonging to page 16k+j. A write replaces the whole word, where 1 forbids and 0 permits, and a read returns the stored value.
- R5: A fetch to 0x040000–0x07FFFF ignores the per-page bits. It faults exactly when the page-63 bit (word 3, bit 15) is 1.
- R6: A fetch to 0x200000–0x3FFFFF faults exactly when addr[23:12] is greater than or equal to config word 4 bits [11:0]. The reset value 0x200 refuses the whole range, and a rewrite applies to every later fetch.
- R7: Fetches to 0x080000–0x1FFFFF and to 0x400000–0xFFFFFF never fault.
- R8: A cycle with fetch_stb low never produces a fault, whatever the address.
- R9: fault is high in the cycle after each offending fetch strobe and for that cycle only. Back-to-back offending fetches give back-to-back high cycles.
- R10: The first fault after reset records its address. Word 5 reads addr[15:0]. Word 6 reads bit 15 = 1 (valid) and bits [7:0] = addr[23:16]. Later faults leave both words unchanged until reset.
- R11: A fetch in the same cycle as a mask write is judged against the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Byte address of the current bus cycle |
| fetch_stb | input | 1 | High when the current cycle is an instruction fetch |
| cfg_we | input | 1 | Write strobe for the config word selected by cfg_addr |
| cfg_addr | input | 3 | Config word select (0..3 mask, 4 boundary, 5/6 fault address) |
| cfg_wdata | input | 16 | Config write data |
| cfg_rdata | output | 16 | Config read data for cfg_addr, combinational |
| fault | output | 1 | Registered execute-violation pulse |

## Verification
The bench builds the unit with its defaults: a 24-bit address, 64 pages of 4 KB and an archive window at 0x200000–0x3FFFFF. With these values the page-63 bit sits in the top bit of the last mask word. The bench can therefore toggle the mirror rule through an ordinary word write and confirm that neighbouring page 62 keeps its own setting. The 12-bit boundary reaches both ends of the archive range: at reset it refuses the whole range, at 0x300 it splits the range, and at 0x400 it opens the range fully. Each of these can be probed on either side of the split.

// File: rtl/xprot_pkg.sv
`timescale 1ns/1ps
package xprot_pkg;

    localparam int unsigned XP_ADDR_W    = 24;
    localparam int unsigned XP_PAGE_SH   = 12;
    localparam int unsigned XP_RAM_PAGES = 64;
    localparam int unsigned XP_CFG_AW    = 3;
    localparam int unsigned XP_CFG_DW    = 16;
    localparam int unsigned XP_OPEN_PAGE = 5;
    localparam logic [XP_ADDR_W-1:0] XP_ARCH_BASE = 24'h200000;
    localparam logic [XP_ADDR_W-1:0] XP_ARCH_LAST = 24'h3FFFFF;

    // Window classification of a bus address.
    typedef enum logic [1:0] {
        RGN_OTHER,
        RGN_RAM,
        RGN_SHADOW,
        RGN_ARCHIVE
    } rgn_e;

    // Result of classification: window and whether a fetch there is refused.
    typedef struct packed {
        rgn_e rgn;
        logic deny;
    } verdict_t;

    // Inclusive range test on addresses widened to 32 bits.
    function automatic logic in_span(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/xprot_classify.sv
`timescale 1ns/1ps
module xprot_classify
    import xprot_pkg::*;
#(
    parameter int unsigned ADDR_W    = XP_ADDR_W,
    parameter int unsigned PAGE_SH   = XP_PAGE_SH,
    parameter int unsigned RAM_PAGES = XP_RAM_PAGES,
    parameter logic [ADDR_W-1:0] ARCH_BASE = XP_ARCH_BASE,
    parameter logic [ADDR_W-1:0] ARCH_LAST = XP_ARCH_LAST
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [RAM_PAGES-1:0]      prot_mask,
    input  logic [ADDR_W-PAGE_SH-1:0] bound_page,
    output verdict_t                  verdict
);

    localparam int unsigned IDX_W   = $clog2(RAM_PAGES);
    localparam int unsigned WIN_LSB = PAGE_SH + IDX_W;
    localparam int unsigned WIN_W   = ADDR_W - WIN_LSB;

    logic [WIN_W-1:0]          win;
    logic [IDX_W-1:0]          pidx;
    logic [ADDR_W-PAGE_SH-1:0] apage;
    logic                      arch_hit;

    assign win      = addr[ADDR_W-1:WIN_LSB];
    assign pidx     = addr[PAGE_SH +: IDX_W];
    assign apage    = addr[ADDR_W-1:PAGE_SH];
    assign arch_hit = in_span(32'(addr), 32'(ARCH_BASE), 32'(ARCH_LAST));

    always_comb begin
        verdict.rgn  = RGN_OTHER;
        verdict.deny = 1'b0;
        if (win == '0) begin
            verdict.rgn  = RGN_RAM;
            verdict.deny = prot_mask[pidx];
        end else if (win == WIN_W'(1)) begin
            // Mirror window inherits the rule of the highest RAM page.
            verdict.rgn  = RGN_SHADOW;
            verdict.deny = prot_mask[RAM_PAGES-1];
        end else if (arch_hit) begin
            verdict.rgn  = RGN_ARCHIVE;
            verdict.deny = (apage >= bound_page);
        end
    end

endmodule

// File: rtl/xprot_cfgregs.sv
`timescale 1ns/1ps
module xprot_cfgregs
    import xprot_pkg::*;
#(
    parameter int unsigned ADDR_W    = XP_ADDR_W,
    parameter int unsigned RAM_PAGES = XP_RAM_PAGES,
    parameter int unsigned DW        = XP_CFG_DW,
    parameter int unsigned AW        = XP_CFG_AW,
    parameter int unsigned BOUND_W   = 12,
    parameter logic [BOUND_W-1:0] BOUND_RST = '0,
    parameter int unsigned OPEN_PAGE = XP_OPEN_PAGE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    input  logic                 flt_valid,
    input  logic [ADDR_W-1:0]    flt_addr,
    output logic [RAM_PAGES-1:0] prot_mask,
    output logic [BOUND_W-1:0]   bound_page,
    output logic [DW-1:0]        rdata
);

    localparam int unsigned WORDS    = RAM_PAGES / DW;
    localparam int unsigned IDX_BND  = WORDS;
    localparam int unsigned IDX_FLO  = WORDS + 1;
    localparam int unsigned IDX_FHI  = WORDS + 2;

    function automatic logic [RAM_PAGES-1:0] reset_mask();
        logic [RAM_PAGES-1:0] m;
        m = '1;
        m[OPEN_PAGE] = 1'b0;
        return m;
    endfunction

    localparam logic [RAM_PAGES-1:0] MASK_RST = reset_mask();

    logic [DW-1:0]      mask_w [WORDS];
    logic [BOUND_W-1:0] bound_q;
    logic [DW-1:0]      flt_hi;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_w[w] <= MASK_RST[w*DW +: DW];
            end else if (we && addr == AW'(w)) begin
                mask_w[w] <= wdata;
            end
        end
        assign prot_mask[w*DW +: DW] = mask_w[w];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q <= BOUND_RST;
        end else if (we && addr == AW'(IDX_BND)) begin
            bound_q <= wdata[BOUND_W-1:0];
        end
    end

    assign bound_page = bound_q;

    always_comb begin
        flt_hi         = DW'(flt_addr >> DW);
        flt_hi[DW-1]   = flt_valid;
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (addr == AW'(w)) rdata = mask_w[w];
        end
        if (addr == AW'(IDX_BND)) rdata = DW'(bound_q);
        if (addr == AW'(IDX_FLO)) rdata = flt_addr[DW-1:0];
        if (addr == AW'(IDX_FHI)) rdata = flt_hi;
    end

endmodule

// File: rtl/xprot_guard.sv
`timescale 1ns/1ps
module xprot_guard
    import xprot_pkg::*;
#(
    parameter int unsigned ADDR_W    = XP_ADDR_W,
    parameter int unsigned PAGE_SH   = XP_PAGE_SH,
    parameter int unsigned RAM_PAGES = XP_RAM_PAGES,
    parameter int unsigned CFG_AW    = XP_CFG_AW,
    parameter int unsigned CFG_DW    = XP_CFG_DW,
    parameter int unsigned OPEN_PAGE = XP_OPEN_PAGE,
    parameter logic [ADDR_W-1:0] ARCH_BASE = XP_ARCH_BASE,
    parameter logic [ADDR_W-1:0] ARCH_LAST = XP_ARCH_LAST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              fetch_stb,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              fault
);

    localparam int unsigned BOUND_W = ADDR_W - PAGE_SH;
    localparam logic [BOUND_W-1:0] BOUND_RST = ARCH_BASE[ADDR_W-1:PAGE_SH];

    logic [RAM_PAGES-1:0] prot_mask;
    logic [BOUND_W-1:0]   bound_page;
    verdict_t             verdict;
    logic                 fault_q;
    logic                 flt_valid;
    logic [ADDR_W-1:0]    flt_addr;
    logic                 violation;

    xprot_cfgregs #(
        .ADDR_W(ADDR_W), .RAM_PAGES(RAM_PAGES), .DW(CFG_DW), .AW(CFG_AW),
        .BOUND_W(BOUND_W), .BOUND_RST(BOUND_RST), .OPEN_PAGE(OPEN_PAGE)
    ) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .flt_valid(flt_valid), .flt_addr(flt_addr),
        .prot_mask(prot_mask), .bound_page(bound_page), .rdata(cfg_rdata)
    );

    xprot_classify #(
        .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .RAM_PAGES(RAM_PAGES),
        .ARCH_BASE(ARCH_BASE), .ARCH_LAST(ARCH_LAST)
    ) u_cls (
        .addr(bus_addr), .prot_mask(prot_mask), .bound_page(bound_page),
        .verdict(verdict)
    );

    assign violation = fetch_stb && verdict.deny;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q   <= 1'b0;
            flt_valid <= 1'b0;
            flt_addr  <= '0;
        end else begin
            fault_q <= violation;
            if (violation && !flt_valid) begin
                flt_valid <= 1'b1;
                flt_addr  <= bus_addr;
            end
        end
    end

    assign fault = fault_q;

endmodule

// File: rtl/xprot_guard_chk.sv
`timescale 1ns/1ps
module xprot_guard_chk #(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned PAGE_SH   = 12,
    parameter int unsigned RAM_PAGES = 64,
    parameter logic [ADDR_W-1:0] ARCH_BASE = 24'h200000,
    parameter logic [ADDR_W-1:0] ARCH_LAST = 24'h3FFFFF
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 fetch_stb,
    input logic                 fault,
    input logic [RAM_PAGES-1:0] prot_mask,
    input logic                 flt_valid,
    input logic [ADDR_W-1:0]    flt_addr
);

    localparam int unsigned IDX_W = $clog2(RAM_PAGES);
    localparam logic [31:0] RAM_SPAN = 32'(RAM_PAGES) << PAGE_SH;

    logic in_ram, in_shadow, in_gap;
    assign in_ram    = 32'(bus_addr) < RAM_SPAN;
    assign in_shadow = (32'(bus_addr) >= RAM_SPAN) && (32'(bus_addr) < 2 * RAM_SPAN);
    assign in_gap    = ((32'(bus_addr) >= 2 * RAM_SPAN) && (bus_addr < ARCH_BASE))
                       || (bus_addr > ARCH_LAST);

    AST_RAM_PAGE_DENY: assert property (@(posedge clk) disable iff (rst)
        fetch_stb && in_ram && prot_mask[bus_addr[PAGE_SH +: IDX_W]] |=> fault); // R2

    AST_SHADOW_TOP_RULE: assert property (@(posedge clk) disable iff (rst)
        fetch_stb && in_shadow |=> fault == $past(prot_mask[RAM_PAGES-1])); // R5

    AST_GAP_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
        fetch_stb && in_gap |=> !fault); // R7

    AST_DATA_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fetch_stb |=> !fault); // R8

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(fetch_stb)); // R9

    AST_FIRST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> flt_valid && $stable(flt_addr)); // R10

endmodule

bind xprot_guard xprot_guard_chk #(
    .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .RAM_PAGES(RAM_PAGES),
    .ARCH_BASE(ARCH_BASE), .ARCH_LAST(ARCH_LAST)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .fetch_stb(fetch_stb),
    .fault(fault), .prot_mask(prot_mask), .flt_valid(flt_valid), .flt_addr(flt_addr)
);

// File: tb/xprot_guard_test.sv
`timescale 1ns/1ps
module xprot_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus_addr = '0;
    logic        fetch_stb = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        fault;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic        exp;
        logic [23:0] addr;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    xprot_guard uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .fetch_stb(fetch_stb),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fault(fault)
    );

    // Monitor: the fault for a cycle's strobe is visible at the following falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            vectors++;
            if (fault !== it.exp) begin
                miscompares++;
                $display("FAIL %s addr=%06h fault actual=%0b expected=%0b",
                         it.tag, it.addr, fault, it.exp);
            end
        end
    end

    // One bus cycle; strobe selects fetch or data access.
    task automatic cyc(input logic [23:0] a, input logic stb, input logic exp, input string tag);
        @(negedge clk);
        bus_addr  = a;
        fetch_stb = stb;
        cfg_we    = 1'b0;
        @(posedge clk);
        #1;
        fetch_stb = 1'b0;
        sb.push_back('{exp, a, tag});
    endtask

    task automatic wr(input logic [2:0] ra, input logic [15:0] d);
        @(negedge clk);
        cfg_addr  = ra;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    // Fetch and config write in the same cycle.
    task automatic fetch_wr(input logic [23:0] a, input logic [2:0] ra, input logic [15:0] d,
                            input logic exp, input string tag);
        @(negedge clk);
        bus_addr  = a;
        fetch_stb = 1'b1;
        cfg_addr  = ra;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(posedge clk);
        #1;
        fetch_stb = 1'b0;
        cfg_we    = 1'b0;
        sb.push_back('{exp, a, tag});
    endtask

    task automatic rd(input logic [2:0] ra, input logic [15:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = ra;
        cfg_we   = 1'b0;
        #1;
        vectors++;
        if (cfg_rdata !== exp) begin
            miscompares++;
            $display("FAIL %s word=%0d rdata actual=%04h expected=%04h", tag, ra, cfg_rdata, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        vectors++;
        if (fault !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 fault after reset actual=%0b expected=0", fault);
        end

        // R1 reset state
        rd(3'd0, 16'hFFDF, "R1");
        rd(3'd1, 16'hFFFF, "R1");
        rd(3'd2, 16'hFFFF, "R1");
        rd(3'd3, 16'hFFFF, "R1");
        rd(3'd4, 16'h0200, "R1");
        rd(3'd5, 16'h0000, "R1");
        rd(3'd6, 16'h0000, "R1");

        // R3 open page and its neighbour; R9 pulse drops
        cyc(24'h005800, 1'b1, 1'b0, "R3");
        cyc(24'h004FFE, 1'b1, 1'b1, "R3");
        cyc(24'h005000, 1'b1, 1'b0, "R9");
        // R8 data access to a forbidden page
        cyc(24'h010000, 1'b0, 1'b0, "R8");
        cyc(24'h07F000, 1'b0, 1'b0, "R8");

        // R10 first fault recorded
        rd(3'd5, 16'h4FFE, "R10");
        rd(3'd6, 16'h8000, "R10");

        // R4 / R2 mask rewrite: open page 6
        wr(3'd0, 16'hFF9F);
        rd(3'd0, 16'hFF9F, "R4");
        cyc(24'h006010, 1'b1, 1'b0, "R2");
        cyc(24'h007000, 1'b1, 1'b1, "R2");
        rd(3'd5, 16'h4FFE, "R10");

        // R4 / R2 on a different word
        wr(3'd2, 16'h0000);
        rd(3'd2, 16'h0000, "R4");
        cyc(24'h02F000, 1'b1, 1'b0, "R2");
        cyc(24'h030000, 1'b1, 1'b1, "R2");

        // R5 mirror window follows page 63 only
        cyc(24'h045800, 1'b1, 1'b1, "R5");
        wr(3'd3, 16'h7FFF);
        rd(3'd3, 16'h7FFF, "R4");
        cyc(24'h07FFFE, 1'b1, 1'b0, "R5");
        cyc(24'h040000, 1'b1, 1'b0, "R5");
        cyc(24'h03E000, 1'b1, 1'b1, "R2");
        cyc(24'h03F000, 1'b1, 1'b0, "R2");
        wr(3'd3, 16'hFFFF);
        cyc(24'h06F000, 1'b1, 1'b1, "R5");

        // R6 archive boundary
        cyc(24'h200000, 1'b1, 1'b1, "R6");
        cyc(24'h3FFFFF, 1'b1, 1'b1, "R6");
        wr(3'd4, 16'h0300);
        rd(3'd4, 16'h0300, "R6");
        cyc(24'h2FFFFE, 1'b1, 1'b0, "R6");
        cyc(24'h300000, 1'b1, 1'b1, "R6");
        wr(3'd4, 16'h0400);
        cyc(24'h3FF000, 1'b1, 1'b0, "R6");
        cyc(24'h200000, 1'b1, 1'b0, "R6");

        // R7 unmapped ranges
        cyc(24'h080000, 1'b1, 1'b0, "R7");
        cyc(24'h1FFFFE, 1'b1, 1'b0, "R7");
        cyc(24'h400000, 1'b1, 1'b0, "R7");
        cyc(24'hFFFFFE, 1'b1, 1'b0, "R7");

        // R11 fetch judged on old mask during write
        fetch_wr(24'h005000, 3'd0, 16'hFFFF, 1'b0, "R11");
        cyc(24'h005000, 1'b1, 1'b1, "R11");

        // R9 back-to-back offending fetches, then idle
        cyc(24'h007000, 1'b1, 1'b1, "R9");
        cyc(24'h004000, 1'b1, 1'b1, "R9");
        cyc(24'h004000, 1'b0, 1'b0, "R9");

        // R10 still holds the first address; cleared by reset
        rd(3'd5, 16'h4FFE, "R10");
        rd(3'd6, 16'h8000, "R10");
        do_reset();
        rd(3'd6, 16'h0000, "R10");
        rd(3'd5, 16'h0000, "R10");
        rd(3'd0, 16'hFFDF, "R1");
        rd(3'd4, 16'h0200, "R1");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule